// File: doc/BRIEF.md
# DRAM Timing Parameter Calculator

This block turns the raw per-module timing bytes of two memory slots into the clock counts a DRAM controller programs into its timing fields. Each parameter is first reduced to the worse of the two slots. It is then converted from nanoseconds to memory clocks at the memory clock rate, which is half the bus speed given in MHz. The block also derives the row cycle time, the refresh-to-active count, the write-to-read turnaround and the refresh interval.

A one-cycle `start` strobe samples every input and launches the calculation. One multiplier and one bit-serial ceiling divider are shared by all the conversions, and a small sequencer runs them one after another. When the last field is written the block pulses `done` for one cycle. The results then stay on the outputs until the next calculation rewrites them.

Top module: `dram_timing_calc`

## Requirements
- R1: The memory clock used in every conversion is the bus speed shifted right by one (floor of bus MHz / 2). All inputs are sampled in the cycle `start` is accepted.
- R2: For each of the five timing bytes (active, precharge, RAS-to-CAS, row-to-row, refresh-to-active), a slot byte of 0xFF counts as 0, and the larger of the two slots' values is used.
- R3: `act2pre` holds the low 4 bits of ceil(active_ns × mem_mhz / 1000). The result is rounded up whenever the remainder is nonzero.
- R4: `pre2act`, `act2cmd` and `act2act` hold the low 3 bits of ceil((byte >> 2) × mem_mhz / 1000) for the precharge, RAS-to-CAS and row-to-row bytes, which are in quarter nanoseconds.
- R5: `row_cycle` holds the low 4 bits of `act2pre + pre2act`.
- R6: `ref2act` holds the low 5 bits of ceil(refresh_ns × mem_mhz / 1000) when the worst-case refresh-to-active byte is nonzero. When that byte is 0, `ref2act` is `row_cycle + 1`.
- R7: `wr2rd` is 2 when mem_mhz is greater than 198, and 1 otherwise.
- R8: The low nibble of each slot's refresh byte, clamped to 5, selects a rate from {15,3,7,31,62,125} (code 0 to 5). The smaller of the two rates is used, and `ref_interval` = floor(rate × mem_mhz / 16).
- R9: A `start` that arrives while a calculation is running is ignored, and input changes after the accepted `start` do not affect the results.
- R10: `done` is high for exactly one cycle per calculation. At that point all outputs hold the new results, and they stay unchanged until the next calculation completes.
- R11: After reset all result outputs are 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe |
| bus_mhz | input | 10 | Bus speed in MHz |
| s0_tras | input | 8 | Slot 0 row active time, ns |
| s1_tras | input | 8 | Slot 1 row active time, ns |
| s0_trp | input | 8 | Slot 0 row precharge, quarter ns |
| s1_trp | input | 8 | Slot 1 row precharge, quarter ns |
| s0_trcd | input | 8 | Slot 0 RAS-to-CAS, quarter ns |
| s1_trcd | input | 8 | Slot 1 RAS-to-CAS, quarter ns |
| s0_trrd | input | 8 | Slot 0 row-to-row, quarter ns |
| s1_trrd | input | 8 | Slot 1 row-to-row, quarter ns |
| s0_trfc | input | 8 | Slot 0 refresh-to-active, ns |
| s1_trfc | input | 8 | Slot 1 refresh-to-active, ns |
| s0_refr | input | 8 | Slot 0 refresh code byte |
| s1_refr | input | 8 | Slot 1 refresh code byte |
| done | output | 1 | One-cycle completion pulse |
| act2pre | output | 4 | Active-to-precharge clocks |
| pre2act | output | 3 | Precharge-to-active clocks |
| act2cmd | output | 3 | RAS-to-CAS clocks |
| act2act | output | 3 | Row-to-row clocks |
| row_cycle | output | 4 | Row cycle clocks |
| ref2act | output | 5 | Refresh-to-active clocks |
| wr2rd | output | 3 | Write-to-read clocks |
| ref_interval | output | 16 | Refresh interval count |

## Verification
The bench builds the block with its default widths: 8-bit timing bytes, a 10-bit bus speed and a divisor of 1000. With these values the products reach 17 bits, so the divider runs over its full width. Bus speeds near 397 to 399 MHz reach the 198/199 MHz write-to-read boundary. Random bytes large enough to overflow the 3-, 4- and 5-bit fields exercise the truncation rules, and exact multiples of 1000 exercise the no-remainder path of the rounding.

// File: rtl/dtc_pkg.sv
// Shared types and helpers for the DRAM timing calculator.
// Assumes refresh codes arrive as raw bytes; only the low nibble is meaningful.
package dtc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} dtc_state_e;

    localparam int N_PARAMS = 5;
    localparam int IX_RAS   = 0;
    localparam int IX_RP    = 1;
    localparam int IX_RCD   = 2;
    localparam int IX_RRD   = 3;
    localparam int IX_RFC   = 4;

    // Refresh rate lookup: low nibble clamped to 5
    function automatic logic [7:0] refresh_rate(input logic [7:0] raw);
        logic [7:0] code;
        code = raw & 8'h0F;
        case (code)
            8'd0:    refresh_rate = 8'd15;
            8'd1:    refresh_rate = 8'd3;
            8'd2:    refresh_rate = 8'd7;
            8'd3:    refresh_rate = 8'd31;
            8'd4:    refresh_rate = 8'd62;
            default: refresh_rate = 8'd125;
        endcase
    endfunction
endpackage

// File: rtl/dtc_worst.sv
// Worst-case selector for one timing parameter across two slots.
// Assumes an all-ones byte marks an absent value, which is treated as zero.
module dtc_worst #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;

    // Replace absent markers with zero, then take the larger value
    always_comb begin
        a_eff = (a == {W{1'b1}}) ? '0 : a;
        b_eff = (b == {W{1'b1}}) ? '0 : b;
        y     = (a_eff > b_eff) ? a_eff : b_eff;
    end
endmodule

// File: rtl/dtc_ceil_div.sv
// Bit-serial restoring divider by a constant, rounding the quotient up.
// Takes NUM_W cycles after go; fin pulses one cycle with quo valid in that cycle.
// Assumes go is not raised while a division is in progress.
module dtc_ceil_div #(
    parameter int NUM_W   = 17,
    parameter int DIVISOR = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int REM_W = $clog2(DIVISOR) + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [REM_W-1:0] DIV_V = REM_W'(DIVISOR);

    logic [NUM_W-1:0] sh_q;
    logic [NUM_W-1:0] q_q;
    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [REM_W-1:0] trial;

    // Next partial remainder: shift in the next dividend bit
    always_comb trial = {rem_q[REM_W-2:0], sh_q[NUM_W-1]};

    // One quotient bit per cycle while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            q_q      <= '0;
            rem_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                sh_q     <= num;
                q_q      <= '0;
                rem_q    <= '0;
                cnt_q    <= CNT_W'(NUM_W);
                active_q <= 1'b1;
            end else if (active_q) begin
                if (trial >= DIV_V) begin
                    rem_q <= trial - DIV_V;
                    q_q   <= {q_q[NUM_W-2:0], 1'b1};
                end else begin
                    rem_q <= trial;
                    q_q   <= {q_q[NUM_W-2:0], 1'b0};
                end
                sh_q  <= sh_q << 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    fin      <= 1'b1;
                end
            end
        end
    end

    // Round up on any nonzero remainder
    always_comb quo = q_q + NUM_W'(rem_q != '0);

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q < DIV_V);                                             // R3
    AST_FIN_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !active_q);                                         // R3
endmodule

// File: rtl/dram_timing_calc.sv
// DRAM timing parameter calculator: turns two slots' timing bytes into
// controller clock counts with one shared multiplier and divider.
// Assumes start is a single-cycle strobe; results are valid at done and
// held until the next calculation completes.
module dram_timing_calc #(
    parameter int SPD_W     = 8,
    parameter int BUS_W     = 10,
    parameter int RAS_W     = 4,
    parameter int RP_W      = 3,
    parameter int RCD_W     = 3,
    parameter int RRD_W     = 3,
    parameter int RC_W      = 4,
    parameter int RFC_W     = 5,
    parameter int WTR_W     = 3,
    parameter int REFI_W    = 16,
    parameter int NS_DIV    = 1000,
    parameter int WTR_LIMIT = 198,
    parameter int REFI_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUS_W-1:0]  bus_mhz,
    input  logic [SPD_W-1:0]  s0_tras,
    input  logic [SPD_W-1:0]  s1_tras,
    input  logic [SPD_W-1:0]  s0_trp,
    input  logic [SPD_W-1:0]  s1_trp,
    input  logic [SPD_W-1:0]  s0_trcd,
    input  logic [SPD_W-1:0]  s1_trcd,
    input  logic [SPD_W-1:0]  s0_trrd,
    input  logic [SPD_W-1:0]  s1_trrd,
    input  logic [SPD_W-1:0]  s0_trfc,
    input  logic [SPD_W-1:0]  s1_trfc,
    input  logic [SPD_W-1:0]  s0_refr,
    input  logic [SPD_W-1:0]  s1_refr,
    output logic              done,
    output logic [RAS_W-1:0]  act2pre,
    output logic [RP_W-1:0]   pre2act,
    output logic [RCD_W-1:0]  act2cmd,
    output logic [RRD_W-1:0]  act2act,
    output logic [RC_W-1:0]   row_cycle,
    output logic [RFC_W-1:0]  ref2act,
    output logic [WTR_W-1:0]  wr2rd,
    output logic [REFI_W-1:0] ref_interval
);
    import dtc_pkg::*;

    localparam int PROD_W = SPD_W + BUS_W;
    localparam int IDX_W  = $clog2(N_PARAMS);
    localparam int SUM_W  = RC_W + 1;

    logic [SPD_W-1:0] slot_a [N_PARAMS];
    logic [SPD_W-1:0] slot_b [N_PARAMS];
    logic [SPD_W-1:0] w_in   [N_PARAMS];
    logic [SPD_W-1:0] w_r    [N_PARAMS];
    logic [BUS_W-1:0] mem_r;
    logic [SPD_W-1:0] rate_r;
    logic [SPD_W-1:0] rate0;
    logic [SPD_W-1:0] rate1;
    logic [IDX_W-1:0] idx_q;
    dtc_state_e       state_q;
    logic [SPD_W-1:0] mul_op;
    logic [PROD_W-1:0] prod;
    logic             div_go;
    logic             div_fin;
    logic [PROD_W-1:0] quo;
    logic [RC_W-1:0]  rc_now;

    // Gather slot bytes into arrays for the selector bank
    always_comb begin
        slot_a[IX_RAS] = s0_tras;  slot_b[IX_RAS] = s1_tras;
        slot_a[IX_RP]  = s0_trp;   slot_b[IX_RP]  = s1_trp;
        slot_a[IX_RCD] = s0_trcd;  slot_b[IX_RCD] = s1_trcd;
        slot_a[IX_RRD] = s0_trrd;  slot_b[IX_RRD] = s1_trrd;
        slot_a[IX_RFC] = s0_trfc;  slot_b[IX_RFC] = s1_trfc;
    end

    for (genvar g = 0; g < N_PARAMS; g++) begin : g_worst
        dtc_worst #(.W(SPD_W)) u_worst (
            .a (slot_a[g]),
            .b (slot_b[g]),
            .y (w_in[g])
        );
    end

    // Faster refresh rate of the two slots
    always_comb begin
        rate0 = refresh_rate(s0_refr);
        rate1 = refresh_rate(s1_refr);
    end

    // Shared multiplier operand: quarter-ns fields are scaled, refresh rate in final step
    always_comb begin
        if (state_q == ST_FIN)
            mul_op = rate_r;
        else if (idx_q == IDX_W'(IX_RAS) || idx_q == IDX_W'(IX_RFC))
            mul_op = w_r[idx_q];
        else
            mul_op = w_r[idx_q] >> 2;
        prod = PROD_W'(mul_op) * PROD_W'(mem_r);
    end

    // Row cycle from the two stored fields
    always_comb rc_now = RC_W'(SUM_W'(act2pre) + SUM_W'(pre2act));

    dtc_ceil_div #(.NUM_W(PROD_W), .DIVISOR(NS_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (prod),
        .fin   (div_fin),
        .quo   (quo)
    );

    // Sequencer: capture, convert each field in turn, then finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            idx_q        <= '0;
            mem_r        <= '0;
            rate_r       <= '0;
            div_go       <= 1'b0;
            done         <= 1'b0;
            act2pre      <= '0;
            pre2act      <= '0;
            act2cmd      <= '0;
            act2act      <= '0;
            row_cycle    <= '0;
            ref2act      <= '0;
            wr2rd        <= '0;
            ref_interval <= '0;
            for (int i = 0; i < N_PARAMS; i++) w_r[i] <= '0;
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    for (int i = 0; i < N_PARAMS; i++) w_r[i] <= w_in[i];
                    mem_r   <= bus_mhz >> 1;
                    rate_r  <= (rate0 < rate1) ? rate0 : rate1;
                    idx_q   <= '0;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (idx_q == IDX_W'(IX_RFC) && w_r[IX_RFC] == '0) begin
                        ref2act <= RFC_W'(rc_now) + RFC_W'(1);
                        state_q <= ST_FIN;
                    end else begin
                        div_go  <= 1'b1;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: if (div_fin) begin
                    case (idx_q)
                        IDX_W'(IX_RAS): act2pre <= RAS_W'(quo);
                        IDX_W'(IX_RP):  pre2act <= RP_W'(quo);
                        IDX_W'(IX_RCD): act2cmd <= RCD_W'(quo);
                        IDX_W'(IX_RRD): act2act <= RRD_W'(quo);
                        default:        ref2act <= RFC_W'(quo);
                    endcase
                    if (idx_q == IDX_W'(IX_RFC)) begin
                        state_q <= ST_FIN;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_ISSUE;
                    end
                end
                default: begin
                    row_cycle    <= rc_now;
                    wr2rd        <= (mem_r > BUS_W'(WTR_LIMIT)) ? WTR_W'(2) : WTR_W'(1);
                    ref_interval <= REFI_W'(prod >> REFI_SHIFT);
                    done         <= 1'b1;
                    state_q      <= ST_IDLE;
                end
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                // R10
    AST_WTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr2rd == WTR_W'(1) || wr2rd == WTR_W'(2)));           // R7
    AST_RC_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> row_cycle == RC_W'(SUM_W'(act2pre) + SUM_W'(pre2act))); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> $stable(mem_r) && $stable(rate_r)); // R9
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(ref_interval) && $stable(row_cycle)); // R10
endmodule

// File: tb/dram_timing_calc_tb_top.sv
// Self-checking bench: directed corners plus seeded random calculations.
module dram_timing_calc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [9:0] bus_mhz;
    logic [7:0] s0_tras, s1_tras, s0_trp, s1_trp, s0_trcd, s1_trcd;
    logic [7:0] s0_trrd, s1_trrd, s0_trfc, s1_trfc, s0_refr, s1_refr;
    logic       done;
    logic [3:0] act2pre;
    logic [2:0] pre2act, act2cmd, act2act;
    logic [3:0] row_cycle;
    logic [4:0] ref2act;
    logic [2:0] wr2rd;
    logic [15:0] ref_interval;

    int checks = 0;
    int errors = 0;
    int e_ras, e_rp, e_rcd, e_rrd, e_rc, e_rfc, e_wtr, e_refi;

    always #2 clk = ~clk;

    dram_timing_calc dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
        .s0_tras(s0_tras), .s1_tras(s1_tras), .s0_trp(s0_trp), .s1_trp(s1_trp),
        .s0_trcd(s0_trcd), .s1_trcd(s1_trcd), .s0_trrd(s0_trrd), .s1_trrd(s1_trrd),
        .s0_trfc(s0_trfc), .s1_trfc(s1_trfc), .s0_refr(s0_refr), .s1_refr(s1_refr),
        .done(done), .act2pre(act2pre), .pre2act(pre2act), .act2cmd(act2cmd),
        .act2act(act2act), .row_cycle(row_cycle), .ref2act(ref2act), .wr2rd(wr2rd),
        .ref_interval(ref_interval)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int worst(input int a, input int b);
        int x = (a == 255) ? 0 : a;
        int y = (b == 255) ? 0 : b;
        return (x > y) ? x : y;
    endfunction

    function automatic int cdiv(input int ns, input int mem);
        return (ns * mem + 999) / 1000;
    endfunction

    function automatic int rate_of(input int raw);
        int c = raw & 15;
        if (c > 5) c = 5;
        case (c)
            0: return 15;
            1: return 3;
            2: return 7;
            3: return 31;
            4: return 62;
            default: return 125;
        endcase
    endfunction

    // Reference model from R1..R8
    task automatic model();
        int mem = bus_mhz / 2;
        int rfc = worst(s0_trfc, s1_trfc);
        int r0 = rate_of(s0_refr);
        int r1 = rate_of(s1_refr);
        e_ras = cdiv(worst(s0_tras, s1_tras), mem) % 16;
        e_rp  = cdiv(worst(s0_trp, s1_trp) / 4, mem) % 8;
        e_rcd = cdiv(worst(s0_trcd, s1_trcd) / 4, mem) % 8;
        e_rrd = cdiv(worst(s0_trrd, s1_trrd) / 4, mem) % 8;
        e_rc  = (e_ras + e_rp) % 16;
        e_rfc = (rfc != 0) ? cdiv(rfc, mem) % 32 : e_rc + 1;
        e_wtr = (mem > 198) ? 2 : 1;
        e_refi = (((r0 < r1) ? r0 : r1) * mem) / 16;
    endtask

    task automatic set_all(input int bus, input int ras0, input int ras1, input int rp0, input int rp1,
                           input int rcd0, input int rcd1, input int rrd0, input int rrd1,
                           input int rfc0, input int rfc1, input int rf0, input int rf1);
        bus_mhz = 10'(bus);
        s0_tras = 8'(ras0); s1_tras = 8'(ras1); s0_trp = 8'(rp0); s1_trp = 8'(rp1);
        s0_trcd = 8'(rcd0); s1_trcd = 8'(rcd1); s0_trrd = 8'(rrd0); s1_trrd = 8'(rrd1);
        s0_trfc = 8'(rfc0); s1_trfc = 8'(rfc1); s0_refr = 8'(rf0); s1_refr = 8'(rf1);
    endtask

    task automatic randomize_inputs();
        int v [13];
        foreach (v[i]) v[i] = ($urandom_range(0, 7) == 0) ? 255 : $urandom_range(0, 254);
        if ($urandom_range(0, 5) == 0) begin v[9] = 0; v[10] = 255; end
        set_all($urandom_range(100, 1023), v[1], v[2], v[3], v[4], v[5], v[6],
                v[7], v[8], v[9], v[10], v[11], v[12]);
    endtask

    // Wait for done with a cycle limit; returns 0 on timeout
    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        if (!ok) check("R10 watchdog", 0, 1);
    endtask

    task automatic compare(input string tag);
        check({tag, " R3 act2pre"}, act2pre, e_ras);
        check({tag, " R4 pre2act"}, pre2act, e_rp);
        check({tag, " R4 act2cmd"}, act2cmd, e_rcd);
        check({tag, " R4 act2act"}, act2act, e_rrd);
        check({tag, " R5 row_cycle"}, row_cycle, e_rc);
        check({tag, " R6 ref2act"}, ref2act, e_rfc);
        check({tag, " R7 wr2rd"}, wr2rd, e_wtr);
        check({tag, " R8 ref_interval"}, ref_interval, e_refi);
    endtask

    // One full calculation with the current inputs (R1, R2 via model)
    task automatic run(input string tag);
        bit ok;
        model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(ok);
        if (ok) begin
            compare(tag);
            @(negedge clk);
            check({tag, " R10 done one cycle"}, done, 0);
        end
    endtask

    initial begin
        bit ok;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; start = 1'b0;
        set_all(400, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 done", done, 0);
        check("R11 ref_interval", ref_interval, 0);
        check("R11 act2pre", act2pre, 0);
        check("R11 wr2rd", wr2rd, 0);

        // R6 fallback with all zero bytes, R8 code 0
        set_all(266, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);   run("zero");
        // R2 absent markers, R6 fallback with FF/0 refresh bytes
        set_all(400, 255, 45, 60, 255, 80, 80, 255, 40, 255, 0, 255, 2); run("absent");
        // R7 boundary: 397 -> 198 MHz, 398 -> 199 MHz
        set_all(397, 40, 40, 60, 60, 60, 60, 40, 40, 70, 70, 1, 1); run("wtr198");
        set_all(398, 40, 40, 60, 60, 60, 60, 40, 40, 70, 70, 1, 1); run("wtr199");
        // R3 exact multiple of 1000 (no round up): 50 ns * 200 MHz
        set_all(400, 50, 20, 20, 0, 20, 20, 20, 20, 50, 10, 5, 9);  run("exact");
        // R1 odd bus speed floors, R8 clamp above 5
        set_all(333, 42, 39, 75, 72, 77, 60, 48, 50, 105, 80, 15, 12); run("odd");

        // R9: second start mid-run and input changes are ignored
        set_all(300, 45, 40, 60, 60, 64, 60, 40, 40, 75, 70, 3, 4);
        model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        randomize_inputs();
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(ok);
        if (ok) begin
            compare("R9 busy");
            // R10 hold: outputs unchanged without a new start
            randomize_inputs();
            repeat (40) @(negedge clk);
            check("R10 hold ref_interval", ref_interval, e_refi);
            check("R10 hold ref2act", ref2act, e_rfc);
            check("R10 no extra done", done, 0);
        end

        for (int k = 0; k < 250; k++) begin
            randomize_inputs();
            run("random R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule